// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with One-Time Disable

This block guards a processor against a stalled program. A prescaler divides the clock, and each prescaler tick lowers a 16-bit count by one. When the count is already zero at a tick, the block escalates in two steps. The first expiry emits a top-priority interrupt pulse, reloads the count from a separate grace-delay field and arms the reset. If software does not rewrite the configuration before the count runs out again, the second expiry emits a one-cycle system reset pulse. It also latches a cause code that survives that pulse, and it returns its own settings to their power-on values.

Software services the watchdog through a simple write bus at two addresses. A write to the configure address loads a new count, prescale and grace delay, clears the arming and starts the watchdog. A write to the trap-door address switches the watchdog off, but only while it is still in its initial state. It must come before any configure write. A disabled watchdog parks itself at its next prescaler tick. Only a later configure write brings it back. Routing the reset pulse to the rest of the chip is left to the surrounding logic.

Top module: `wdg_top`

## Requirements
- R1: After power-on reset, irq_o and sys_rst_o are low, cause_o is 0 and mode_o reads 0 (initial mode).
- R2: A write to address 0 loads the configure word. Count is bits 15:0, prescale is bits 23:16 and grace delay is bits 31:24. The write clears the arming, sets mode_o to 2 (running) and restarts the prescaler.
- R3: The count drops by one every prescale+1 cycles. With count C and prescale P, a one-cycle irq_o pulse first appears (C+1)*(P+1) clock edges after the configure write edge.
- R4: At the first expiry the count is reloaded from the grace delay D and reset is armed. A one-cycle sys_rst_o pulse follows (D+1)*(P+1) edges after the irq_o edge. irq_o and sys_rst_o are never high together.
- R5: With the sys_rst_o pulse, cause_o becomes 0xC000 and keeps that value until the next power-on reset. The watchdog's own settings return to their defaults (count 0xFFFF, prescale 255, delay 255, disarmed), and mode_o returns to 0.
- R6: A write to address 1 while mode_o is 0 sets mode_o to 1 (disabled).
- R7: A write to address 1 in any mode other than 0 has no effect.
- R8: A disabled watchdog moves to mode 3 (stopped) at its next prescaler tick. Once stopped, it holds there and never pulses irq_o or sys_rst_o.
- R9: A configure write while reset is armed disarms it. The next expiry then gives irq_o, not sys_rst_o.
- R10: A configure write in mode 3 restarts counting with the new settings, following the timing of R3.
- R11: Writes to any address other than 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Write address (0 configure, 1 trap-door) |
| bus_wdata | input | 32 | Write data |
| irq_o | output | 1 | One-cycle interrupt pulse at first expiry |
| sys_rst_o | output | 1 | One-cycle system reset pulse at second expiry |
| cause_o | output | 16 | Reset cause code, 0xC000 after a watchdog reset |
| mode_o | output | 2 | 0 initial, 1 disabled, 2 running, 3 stopped |

## Verification
Every cycle, the assertions check the following. An interrupt only leaves an armed watchdog. Interrupt and reset never coincide. Each reset pulse carries the cause code and a return to the initial mode. A stopped watchdog keeps its mode and count. A trap-door write to a running watchdog never disables it. The prescaler phase never passes its limit. The exact expiry cycles for a given count, prescale and delay can only be shown by the bench's scenarios. The same holds for the disarming effect of a rewrite, the restart from the stopped mode and the survival of the cause code across later activity.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 8;
    localparam int DLY_W  = 8;
    localparam int WORD_W = CNT_W + PRE_W + DLY_W;
    localparam int CODE_W = 16;

    localparam logic [CNT_W-1:0]  CNT_DFLT   = '1;
    localparam logic [PRE_W-1:0]  PRE_DFLT   = '1;
    localparam logic [DLY_W-1:0]  DLY_DFLT   = '1;
    localparam logic [CODE_W-1:0] CAUSE_WDOG = 16'hC000;

    typedef enum logic [1:0] {
        WD_INIT = 2'd0,
        WD_OFF  = 2'd1,
        WD_RUN  = 2'd2,
        WD_HALT = 2'd3
    } wd_mode_e;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } wd_cfg_t;

    function automatic wd_cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
        wd_cfg_t c;
        c.cnt = w[CNT_W-1:0];
        c.pre = w[CNT_W+PRE_W-1:CNT_W];
        c.dly = w[WORD_W-1:CNT_W+PRE_W];
        return c;
    endfunction

    function automatic wd_cfg_t cfg_default();
        wd_cfg_t c;
        c.cnt = CNT_DFLT;
        c.pre = PRE_DFLT;
        c.dly = DLY_DFLT;
        return c;
    endfunction
endpackage

// File: rtl/wdg_bus_decode.sv
module wdg_bus_decode #(
    parameter int ADDR_W    = 4,
    parameter int CFG_ADDR  = 0,
    parameter int TRAP_ADDR = 1
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              cfg_wr,
    output logic              trap_wr
);
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] TRAP_A = ADDR_W'(TRAP_ADDR);

    always_comb begin
        cfg_wr  = wr && (addr == CFG_A);
        trap_wr = wr && (addr == TRAP_A);
    end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] phase_q;

    assign tick = run && (phase_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run) begin
            if (phase_q == limit) phase_q <= '0;
            else                  phase_q <= phase_q + 1'b1;
        end
    end

    // R3: the phase never runs past the divide limit
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
        phase_q <= limit);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              trap_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              tick,
    output logic              run,
    output logic              restart,
    output logic [PRE_W-1:0]  pre_lim,
    output logic              irq_o,
    output logic              sys_rst_o,
    output logic [CODE_W-1:0] cause_o,
    output logic [1:0]        mode_o
);
    wd_mode_e          state_q;
    wd_cfg_t           set_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              armed_q;
    logic              irq_q, srst_q;
    logic [CODE_W-1:0] cause_q;

    logic trap_take, counting, at_zero, fire_rst, fire_irq;

    always_comb begin
        trap_take = trap_wr && (state_q == WD_INIT);
        counting  = tick && !cfg_wr && !trap_take &&
                    (state_q == WD_INIT || state_q == WD_RUN);
        at_zero   = (cnt_q == '0);
        fire_rst  = counting && at_zero && armed_q;
        fire_irq  = counting && at_zero && !armed_q;
    end

    assign run       = (state_q != WD_HALT);
    assign restart   = cfg_wr || fire_rst;
    assign pre_lim   = set_q.pre;
    assign irq_o     = irq_q;
    assign sys_rst_o = srst_q;
    assign cause_o   = cause_q;
    assign mode_o    = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_INIT;
            set_q   <= cfg_default();
            cnt_q   <= CNT_DFLT;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
            srst_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            irq_q  <= 1'b0;
            srst_q <= 1'b0;
            if (cfg_wr) begin
                set_q   <= cfg_unpack(wdata);
                cnt_q   <= cfg_unpack(wdata).cnt;
                armed_q <= 1'b0;
                state_q <= WD_RUN;
            end else if (trap_take) begin
                state_q <= WD_OFF;
            end else if (tick && state_q == WD_OFF) begin
                state_q <= WD_HALT;
            end else if (fire_rst) begin
                srst_q  <= 1'b1;
                cause_q <= CAUSE_WDOG;
                state_q <= WD_INIT;
                set_q   <= cfg_default();
                cnt_q   <= CNT_DFLT;
                armed_q <= 1'b0;
            end else if (fire_irq) begin
                irq_q   <= 1'b1;
                cnt_q   <= CNT_W'(set_q.dly);
                armed_q <= 1'b1;
            end else if (counting) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4: an interrupt only leaves a watchdog that is now armed
    a_r4_irq_arms: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> armed_q);
    // R4: interrupt and reset never share a cycle
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(irq_q && srst_q));
    // R3: the interrupt is a single-cycle pulse
    a_r3_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);
    // R5: reset pulse carries the cause and a return to the initial mode
    a_r5_cause_on_reset: assert property (@(posedge clk) disable iff (rst)
        srst_q |-> (cause_q == CAUSE_WDOG && state_q == WD_INIT && !armed_q));
    // R7: a trap-door write never disables a running watchdog
    a_r7_trap_ignored: assert property (@(posedge clk) disable iff (rst)
        (trap_wr && !cfg_wr && state_q == WD_RUN) |=> state_q != WD_OFF);
    // R8: a stopped watchdog stays put until configured
    a_r8_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_HALT && !cfg_wr) |=> (state_q == WD_HALT && $stable(cnt_q)));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CFG_ADDR  = 0,
    parameter int TRAP_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              irq_o,
    output logic              sys_rst_o,
    output logic [CODE_W-1:0] cause_o,
    output logic [1:0]        mode_o
);
    logic             cfg_wr, trap_wr, tick, run, restart;
    logic [PRE_W-1:0] pre_lim;

    wdg_bus_decode #(
        .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .TRAP_ADDR(TRAP_ADDR)
    ) u_dec (
        .wr(bus_wr), .addr(bus_addr), .cfg_wr(cfg_wr), .trap_wr(trap_wr)
    );

    wdg_prescaler #(.W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .run(run), .restart(restart),
        .limit(pre_lim), .tick(tick)
    );

    wdg_core u_core (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .trap_wr(trap_wr),
        .wdata(bus_wdata), .tick(tick), .run(run), .restart(restart),
        .pre_lim(pre_lim), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
        .cause_o(cause_o), .mode_o(mode_o)
    );
endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        irq_o, sys_rst_o;
    logic [15:0] cause_o;
    logic [1:0]  mode_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdg_top u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
        .cause_o(cause_o), .mode_o(mode_o)
    );

    function automatic int exp_irq(input int c, input int p);
        return (c + 1) * (p + 1);
    endfunction
    function automatic int exp_rst(input int d, input int p);
        return (d + 1) * (p + 1);
    endfunction
    function automatic logic [31:0] cfg_word(input int c, input int p, input int d);
        return {d[7:0], p[7:0], c[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // counts edges after the last write edge; records first pulses
    task automatic watch(input int limit, input bit stop_irq,
                         output int irq_at, output int rst_at,
                         output int irq_n, output int rst_n);
        irq_at = -1; rst_at = -1; irq_n = 0; rst_n = 0;
        for (int n = 1; n <= limit; n++) begin
            @(posedge clk); #1;
            if (irq_o) begin
                irq_n++;
                if (irq_at < 0) irq_at = n;
            end
            if (sys_rst_o) begin
                rst_n++;
                if (rst_at < 0) rst_at = n;
            end
            if (stop_irq && irq_at > 0) break;
        end
    endtask

    task automatic full_run(input int c, input int p, input int d);
        int ia, ra, in_, rn, ei, er;
        ei = exp_irq(c, p);
        er = ei + exp_rst(d, p);
        bus_write(4'd0, cfg_word(c, p, d));
        chk(mode_o == 2'd2, "R2 mode running", mode_o, 2);
        watch(er + 4, 1'b0, ia, ra, in_, rn);
        chk(ia == ei, "R3 irq edge", ia, ei);
        chk(in_ == 1, "R3 irq width", in_, 1);
        chk(ra == er, "R4 reset edge", ra, er);
        chk(rn == 1, "R4 reset width", rn, 1);
        chk(cause_o == 16'hC000, "R5 cause", cause_o, 16'hC000);
        chk(mode_o == 2'd0, "R5 mode initial", mode_o, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int ia, ra, in_, rn, ei;
        void'($urandom(32'd7001));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        // R1
        chk(irq_o == 0 && sys_rst_o == 0, "R1 pulses low", irq_o, 0);
        chk(cause_o == 0, "R1 cause", cause_o, 0);
        chk(mode_o == 2'd0, "R1 mode", mode_o, 0);

        // R11: stray address does nothing
        bus_write(4'd5, 32'h0000_0001);
        chk(mode_o == 2'd0, "R11 stray write", mode_o, 0);

        // R6, R8: trap door in initial mode, then halt at next tick
        bus_write(4'd1, 32'h0);
        chk(mode_o == 2'd1, "R6 disabled", mode_o, 1);
        watch(300, 1'b0, ia, ra, in_, rn);
        chk(mode_o == 2'd3, "R8 stopped", mode_o, 3);
        chk(in_ == 0 && rn == 0, "R8 no pulses", in_ + rn, 0);
        // R7: trap door while stopped is ignored
        bus_write(4'd1, 32'h0);
        chk(mode_o == 2'd3, "R7 trap in stopped", mode_o, 3);

        // R10: restart from stopped, directed
        full_run(3, 2, 2);
        // R5: cause survives further activity; trap door works again
        bus_write(4'd1, 32'h0);
        chk(mode_o == 2'd1, "R5 R6 trap after watchdog reset", mode_o, 1);
        chk(cause_o == 16'hC000, "R5 cause kept", cause_o, 16'hC000);

        // corner: all zero, prescale zero
        full_run(0, 0, 0);

        // R7: trap while running ignored, schedule unchanged
        bus_write(4'd0, cfg_word(4, 1, 3));
        bus_write(4'd1, 32'h0);
        chk(mode_o == 2'd2, "R7 trap in running", mode_o, 2);
        watch(40, 1'b1, ia, ra, in_, rn);
        ei = exp_irq(4, 1) - 1;
        chk(ia == ei, "R7 irq schedule unchanged", ia, ei);

        // R9: rewrite while armed -> next expiry is irq again
        bus_write(4'd0, cfg_word(2, 1, 1));
        watch(40, 1'b0, ia, ra, in_, rn);
        ei = exp_irq(2, 1);
        chk(ia == ei, "R9 irq after rewrite", ia, ei);
        chk(ra == ei + exp_rst(1, 1), "R9 reset follows", ra, ei + exp_rst(1, 1));

        // R3 R4: random configurations
        for (int k = 0; k < 8; k++) begin
            int c, p, d;
            c = int'($urandom % 7);
            p = int'($urandom % 4);
            d = int'($urandom % 7);
            full_run(c, p, d);
        end

        // R1 again: power-on reset clears cause
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        chk(cause_o == 0 && mode_o == 0, "R1 power-on clears", cause_o, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule